// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block sits between a simple host port and a 32-bit EDO DRAM array built from two ranks. It takes one word request at a time, with a read/write flag, a word address, write data and four byte enables, and turns it into a single random read or early-write cycle on a multiplexed 12-bit address bus. There are two row strobes, one per rank, four column strobes, one per byte lane, and one write enable. All strobe timing is counted in clock cycles. With the default parameters the clock is 50 MHz (20 ns), and each nanosecond limit is rounded up to whole cycles.

After reset the controller keeps every strobe inactive for the power-up pause. It then runs a fixed number of CAS-before-RAS refresh cycles and only after that raises `ready` and accepts host requests. From then on a free-running interval timer marks a refresh as owed. The state machine serves an owed refresh in preference to a waiting host request as soon as the current access has finished. If two refreshes are ever owed at the same time, a sticky error flag is raised.

The host word address splits into a rank bit (bit 22), a 12-bit row (bits 21:10) and a 10-bit column (bits 9:0). The column goes onto the bus with its two upper bits low. The state machine has these states: PAUSE (power-up wait), IDLE, ADDR (row address set up with the row strobe high), ROW (row strobe low), COLA (column address set up, write enable settled), STRB (column strobes low), PRE (precharge), REFC (all column strobes low ahead of the row strobes) and REFR (both row strobes low). Its transitions are PAUSE to REFC, IDLE to REFC when a refresh is owed, IDLE to ADDR on a request, ADDR to ROW to COLA to STRB to PRE, REFC to REFR to PRE, PRE to REFC while initial refreshes remain, and PRE to IDLE otherwise.

Top module: `edo_ctrl`

## Requirements
- R1: For the first INIT_CYC cycles after reset every strobe stays inactive: row strobes 2'b11, column strobes 4'b1111 and write enable high. No acknowledge is given in that time.
- R2: After the pause exactly INIT_REFS refresh cycles run before `ready` rises. No `host_ack` is ever given while `ready` is low.
- R3: During a refresh all four column strobes go low at least one cycle before both row strobes fall. They stay low while the row strobes are low, and write enable stays high throughout.
- R4: On an access the bus carries host_addr[21:10] in the cycle before the row strobe falls and in the cycle it falls. It carries {2'b00, host_addr[9:0]} in the cycle before the column strobes fall and in the cycle they fall.
- R5: An access lowers only one row strobe: bit 0 when host_addr[22] is 0 and bit 1 when it is 1. Write enable is low only while exactly one row strobe is low.
- R6: A write is an early write. Write enable is low from the cycle before the column strobes fall until they rise. Column strobe bit i goes low only if host_be[i] is 1, which leaves disabled bytes unchanged in the array. The data bus is driven with the request's write data while the column strobes are low.
- R7: A read lowers all four column strobes with write enable high. The controller captures the data bus in the last cycle the column strobes are low and shows it on `host_rdata`, with `host_rvalid` high for one cycle, in the cycle the row strobe rises.
- R8: A row strobe stays low for at least TRAS_CYC cycles and high for at least TRP_CYC cycles between low periods. Column strobes stay low for at least TCAS_CYC cycles.
- R9: On an access the column strobes fall at least TRCD_CYC+1 cycles after the row strobe falls.
- R10: Once `ready` is high, refreshes come one every REF_INT cycles, with a small latency to let a running access finish. A refresh that is owed is served before a waiting host request.
- R11: `ref_err` rises when a second refresh becomes owed before the first has been served, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 23 | Word address: rank, row, column |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables for writes |
| host_ack | output | 1 | One-cycle pulse when a request is taken |
| host_rdata | output | 32 | Read data |
| host_rvalid | output | 1 | One-cycle pulse with read data |
| ready | output | 1 | Initialization finished |
| ref_err | output | 1 | Sticky flag: two refreshes owed at once |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, one per rank, active low |
| dram_cas_n | output | 4 | Column strobes, one per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 32 | Data toward the array |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 32 | Data from the array |

## Verification
The assertions assume that the host keeps `host_req` and its fields steady until `host_ack`, and that nothing outside the block drives the strobes. They also assume that reset is held for at least one clock so that the strobe history starts from the inactive level. The stimulus keeps within these limits: it raises a request already during the power-up pause, holds it until the acknowledge, and changes the request fields only after the access has completed. A second instance runs with a refresh interval shorter than one refresh cycle, so that it must fall behind and raise the error flag.

// File: rtl/edo_pkg.sv
package edo_pkg;
    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_ADDR,
        ST_ROW,
        ST_COLA,
        ST_STRB,
        ST_PRE,
        ST_REFC,
        ST_REFR
    } edo_state_t;
endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
    parameter int REF_INT = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic done,
    output logic owed,
    output logic err
);
    localparam int CW = $clog2(REF_INT + 1);

    logic [CW-1:0] tcnt;
    logic [1:0]    debt;
    logic          tick;

    assign tick = en && (tcnt == CW'(REF_INT - 1));
    assign owed = (debt != 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
            debt <= 2'd0;
            err  <= 1'b0;
        end else if (en) begin
            tcnt <= tick ? '0 : tcnt + 1'b1;
            if (tick && !done) begin
                if (debt != 2'd0) err <= 1'b1;
                if (debt != 2'd2) debt <= debt + 2'd1;
            end else if (!tick && done && debt != 2'd0) begin
                debt <= debt - 2'd1;
            end
        end
    end
endmodule

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
    parameter int ROW_W = 12,
    parameter int COL_W = 10
) (
    input  logic [ROW_W+COL_W:0] word,
    output logic                 rank,
    output logic [ROW_W-1:0]     row,
    output logic [ROW_W-1:0]     col
);
    assign rank = word[ROW_W+COL_W];
    assign row  = word[ROW_W+COL_W-1:COL_W];

    generate
        if (ROW_W > COL_W) begin : g_pad
            assign col = {{(ROW_W-COL_W){1'b0}}, word[COL_W-1:0]};
        end else begin : g_trunc
            assign col = word[ROW_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int COL_W     = 10,
    parameter int DW        = 32,
    parameter int INIT_CYC  = 10000,
    parameter int INIT_REFS = 8,
    parameter int REF_INT   = 780,
    parameter int TRCD_CYC  = 1,
    parameter int TCAS_CYC  = 1,
    parameter int TCAC_CYC  = 1,
    parameter int TRAC_CYC  = 3,
    parameter int TRAS_CYC  = 3,
    parameter int TRP_CYC   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_req,
    input  logic                   host_wr,
    input  logic [ROW_W+COL_W:0]   host_addr,
    input  logic [DW-1:0]          host_wdata,
    input  logic [DW/8-1:0]        host_be,
    output logic                   host_ack,
    output logic [DW-1:0]          host_rdata,
    output logic                   host_rvalid,
    output logic                   ready,
    output logic                   ref_err,
    output logic [ROW_W-1:0]       dram_addr,
    output logic [1:0]             dram_ras_n,
    output logic [DW/8-1:0]        dram_cas_n,
    output logic                   dram_we_n,
    output logic [DW-1:0]          dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DW-1:0]          dram_dq_in
);
    localparam int NB    = DW / 8;
    localparam int AW    = ROW_W + COL_W + 1;
    localparam int CNT_W = $clog2(INIT_CYC + REF_INT + 64);
    localparam int IL_W  = $clog2(INIT_REFS + 1);

    function automatic int strobe_len();
        int m;
        m = TCAS_CYC;
        if (TCAC_CYC > m) m = TCAC_CYC;
        if (TRAC_CYC - TRCD_CYC - 1 > m) m = TRAC_CYC - TRCD_CYC - 1;
        if (TRAS_CYC - TRCD_CYC - 1 > m) m = TRAS_CYC - TRCD_CYC - 1;
        return m;
    endfunction

    localparam int STRB_CYC = strobe_len();

    edo_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [IL_W-1:0]   init_left;
    logic              init_done;
    logic [AW-1:0]     lat_addr;
    logic              lat_wr;
    logic [DW-1:0]     lat_wdata;
    logic [NB-1:0]     lat_be;
    logic              ack_q;
    logic              rvalid_q;
    logic [DW-1:0]     rdata_q;

    logic              ref_owed;
    logic              ref_done;
    logic              lat_rank;
    logic [ROW_W-1:0]  lat_row;
    logic [ROW_W-1:0]  lat_col;

    assign ref_done = (state == ST_REFR) && (cnt == CNT_W'(TRAS_CYC - 1)) && init_done;

    edo_ref_timer #(.REF_INT(REF_INT)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (init_done),
        .done (ref_done),
        .owed (ref_owed),
        .err  (ref_err)
    );

    edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .word (lat_addr),
        .rank (lat_rank),
        .row  (lat_row),
        .col  (lat_col)
    );

    // state register and request latches
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PAUSE;
            cnt       <= '0;
            init_left <= IL_W'(INIT_REFS);
            init_done <= 1'b0;
            lat_addr  <= '0;
            lat_wr    <= 1'b0;
            lat_wdata <= '0;
            lat_be    <= '0;
            ack_q     <= 1'b0;
            rvalid_q  <= 1'b0;
            rdata_q   <= '0;
        end else begin
            ack_q    <= 1'b0;
            rvalid_q <= 1'b0;
            cnt      <= cnt + 1'b1;
            unique case (state)
                ST_PAUSE: begin
                    if (cnt == CNT_W'(INIT_CYC - 1)) begin
                        state <= ST_REFC;
                        cnt   <= '0;
                    end
                end
                ST_IDLE: begin
                    cnt <= '0;
                    if (ref_owed) begin
                        state <= ST_REFC;
                    end else if (host_req) begin
                        state     <= ST_ADDR;
                        lat_addr  <= host_addr;
                        lat_wr    <= host_wr;
                        lat_wdata <= host_wdata;
                        lat_be    <= host_be;
                        ack_q     <= 1'b1;
                    end
                end
                ST_ADDR: begin
                    state <= ST_ROW;
                    cnt   <= '0;
                end
                ST_ROW: begin
                    if (cnt == CNT_W'(TRCD_CYC - 1)) begin
                        state <= ST_COLA;
                        cnt   <= '0;
                    end
                end
                ST_COLA: begin
                    state <= ST_STRB;
                    cnt   <= '0;
                end
                ST_STRB: begin
                    if (cnt == CNT_W'(STRB_CYC - 1)) begin
                        state <= ST_PRE;
                        cnt   <= '0;
                        if (!lat_wr) begin
                            rdata_q  <= dram_dq_in;
                            rvalid_q <= 1'b1;
                        end
                    end
                end
                ST_PRE: begin
                    if (cnt == CNT_W'(TRP_CYC - 1)) begin
                        cnt <= '0;
                        if (init_left != '0) begin
                            state <= ST_REFC;
                        end else begin
                            state     <= ST_IDLE;
                            init_done <= 1'b1;
                        end
                    end
                end
                ST_REFC: begin
                    state <= ST_REFR;
                    cnt   <= '0;
                end
                ST_REFR: begin
                    if (cnt == CNT_W'(TRAS_CYC - 1)) begin
                        state <= ST_PRE;
                        cnt   <= '0;
                        if (init_left != '0) init_left <= init_left - 1'b1;
                    end
                end
            endcase
        end
    end

    // strobe and bus outputs decoded from the state
    always_comb begin
        dram_ras_n = 2'b11;
        dram_cas_n = '1;
        dram_we_n  = 1'b1;
        dram_addr  = '0;
        dram_dq_oe = 1'b0;
        unique case (state)
            ST_PAUSE, ST_IDLE, ST_PRE: ;
            ST_ADDR: dram_addr = lat_row;
            ST_ROW: begin
                dram_ras_n = lat_rank ? 2'b01 : 2'b10;
                dram_addr  = lat_row;
            end
            ST_COLA: begin
                dram_ras_n = lat_rank ? 2'b01 : 2'b10;
                dram_addr  = lat_col;
                dram_we_n  = !lat_wr;
                dram_dq_oe = lat_wr;
            end
            ST_STRB: begin
                dram_ras_n = lat_rank ? 2'b01 : 2'b10;
                dram_addr  = lat_col;
                dram_we_n  = !lat_wr;
                dram_dq_oe = lat_wr;
                dram_cas_n = lat_wr ? ~lat_be : '0;
            end
            ST_REFC: dram_cas_n = '0;
            ST_REFR: begin
                dram_cas_n = '0;
                dram_ras_n = 2'b00;
            end
        endcase
    end

    assign dram_dq_out = lat_wdata;
    assign host_ack    = ack_q;
    assign host_rvalid = rvalid_q;
    assign host_rdata  = rdata_q;
    assign ready       = init_done;
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int NB       = 4,
    parameter int TRAS_CYC = 3,
    parameter int TRP_CYC  = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    ras_n,
    input logic [NB-1:0] cas_n,
    input logic          we_n,
    input logic          ack,
    input logic          ready,
    input logic          ref_err
);
    logic [1:0]    prev_ras;
    logic [NB-1:0] prev_cas;
    int            hi_cnt;
    int            lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ras <= 2'b11;
            prev_cas <= '1;
            hi_cnt   <= 0;
            lo_cnt   <= 0;
        end else begin
            prev_ras <= ras_n;
            prev_cas <= cas_n;
            if (ras_n == 2'b11) begin
                hi_cnt <= (hi_cnt < 1000000) ? hi_cnt + 1 : hi_cnt;
                lo_cnt <= 0;
            end else begin
                lo_cnt <= (lo_cnt < 1000000) ? lo_cnt + 1 : lo_cnt;
                hi_cnt <= 0;
            end
        end
    end

    a_r2_ack_after_ready: assert property (@(posedge clk) disable iff (rst)
        ack |-> ready);

    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        (ras_n == 2'b00 && prev_ras == 2'b11) |-> (prev_cas == '0));

    a_r3_refresh_shape: assert property (@(posedge clk) disable iff (rst)
        (ras_n == 2'b00) |-> (we_n && cas_n == '0));

    a_r5_write_one_rank: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> ($countones(~ras_n) == 1));

    a_r8_precharge_min: assert property (@(posedge clk) disable iff (rst)
        (ras_n != 2'b11 && prev_ras == 2'b11) |-> (hi_cnt >= TRP_CYC));

    a_r8_active_min: assert property (@(posedge clk) disable iff (rst)
        (ras_n == 2'b11 && prev_ras != 2'b11) |-> (lo_cnt >= TRAS_CYC));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(ref_err) |-> ref_err);
endmodule

bind edo_ctrl edo_ctrl_chk #(
    .NB       (NB),
    .TRAS_CYC (TRAS_CYC),
    .TRP_CYC  (TRP_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ras_n   (dram_ras_n),
    .cas_n   (dram_cas_n),
    .we_n    (dram_we_n),
    .ack     (host_ack),
    .ready   (ready),
    .ref_err (ref_err)
);

// File: tb/sim_edo_ctrl.sv
module sim_edo_ctrl;
    localparam int CLK_NS    = 20;
    localparam int INIT_CYC  = 10000;
    localparam int INIT_REFS = 8;
    localparam int REF_INT   = 780;
    localparam int TRCD_CYC  = 1;
    localparam int TCAS_CYC  = 1;
    localparam int TRAS_CYC  = 3;
    localparam int TRP_CYC   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [22:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic        host_ack, host_rvalid, ready, ref_err;
    logic [31:0] host_rdata;
    logic [11:0] dram_addr;
    logic [1:0]  dram_ras_n;
    logic [3:0]  dram_cas_n;
    logic        dram_we_n, dram_dq_oe;
    logic [31:0] dram_dq_out;
    logic [31:0] dram_dq_in = 32'h0BAD_F00D;

    // second instance with a refresh interval too short to keep up
    logic        b_ack, b_rvalid, b_ready, b_err, b_we_n, b_oe;
    logic [31:0] b_rdata, b_dq_out;
    logic [11:0] b_addr;
    logic [1:0]  b_ras_n;
    logic [3:0]  b_cas_n;

    always #(CLK_NS/2) clk = ~clk;

    edo_ctrl u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ack(host_ack), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .ready(ready), .ref_err(ref_err), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    edo_ctrl #(.INIT_CYC(4), .INIT_REFS(1), .REF_INT(3)) u1 (
        .clk(clk), .rst(rst), .host_req(1'b0), .host_wr(1'b0),
        .host_addr(23'd0), .host_wdata(32'd0), .host_be(4'd0),
        .host_ack(b_ack), .host_rdata(b_rdata), .host_rvalid(b_rvalid),
        .ready(b_ready), .ref_err(b_err), .dram_addr(b_addr),
        .dram_ras_n(b_ras_n), .dram_cas_n(b_cas_n), .dram_we_n(b_we_n),
        .dram_dq_out(b_dq_out), .dram_dq_oe(b_oe), .dram_dq_in(32'd0)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // expected request, owned by the host task
    logic        e_wr;
    logic [22:0] e_a;
    logic [31:0] e_d;
    logic [3:0]  e_be;

    logic [31:0] hmem [int];   // host-side expected contents
    logic [31:0] dmem [int];   // array model addressed from the pins

    // pin monitor and array model
    int          cyc = 0;
    bit          seen_act = 0;
    int          init_refs = 0;
    int          late_refs = 0;
    int          last_ref = -1;
    int          ras_hi = 0, ras_lo = 0, cas_lo = 0, since_fall = 0;
    logic [1:0]  p_ras = 2'b11;
    logic [3:0]  p_cas = 4'hF;
    logic        p_we = 1'b1;
    logic [11:0] p_addr = '0;
    logic        d_rank;
    logic [11:0] d_row;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (!seen_act && (dram_ras_n != 2'b11 || dram_cas_n != 4'hF || !dram_we_n)) begin
                seen_act = 1;
                chk(cyc >= INIT_CYC, "R1 first strobe after pause", 64'(cyc), 64'(INIT_CYC));
            end
            // row strobe falling
            if (p_ras == 2'b11 && dram_ras_n != 2'b11) begin
                chk(ras_hi >= TRP_CYC, "R8 precharge width", 64'(ras_hi), 64'(TRP_CYC));
                if (dram_ras_n == 2'b00) begin
                    chk(p_cas == 4'h0 && dram_cas_n == 4'h0 && dram_we_n && p_we,
                        "R3 cbr order", {p_cas, dram_cas_n, 3'b0, dram_we_n}, 64'h0001);
                    if (!ready) init_refs++;
                    else begin
                        late_refs++;
                        chk(cyc - last_ref <= REF_INT + 20 && cyc - last_ref >= REF_INT - 12,
                            "R10 refresh interval", 64'(cyc - last_ref), 64'(REF_INT));
                    end
                    last_ref = cyc;
                end else begin
                    chk(dram_ras_n == (e_a[22] ? 2'b01 : 2'b10), "R5 rank strobe",
                        64'(dram_ras_n), 64'(e_a[22] ? 2'b01 : 2'b10));
                    chk(dram_addr == e_a[21:10] && p_addr == e_a[21:10], "R4 row address",
                        {p_addr, dram_addr}, {e_a[21:10], e_a[21:10]});
                    d_rank = (dram_ras_n == 2'b01);
                    d_row  = dram_addr;
                    since_fall = 0;
                end
            end
            // column strobes falling inside an access
            if (p_cas == 4'hF && dram_cas_n != 4'hF && dram_ras_n != 2'b11) begin
                int key;
                key = (int'(d_rank) << 24) | (int'(d_row) << 12) | int'(dram_addr);
                chk(since_fall >= TRCD_CYC + 1, "R9 row to column delay", 64'(since_fall), 64'(TRCD_CYC + 1));
                chk(dram_addr == {2'b00, e_a[9:0]} && p_addr == {2'b00, e_a[9:0]}, "R4 column address",
                    {p_addr, dram_addr}, {2'b00, e_a[9:0], 2'b00, e_a[9:0]});
                if (e_wr) begin
                    chk(dram_cas_n == ~e_be && !dram_we_n && !p_we && dram_dq_oe && dram_dq_out == e_d,
                        "R6 early write lanes", {dram_cas_n, dram_we_n, p_we, dram_dq_oe, dram_dq_out},
                        {~e_be, 1'b0, 1'b0, 1'b1, e_d});
                    begin
                        logic [31:0] w;
                        w = dmem.exists(key) ? dmem[key] : 32'h0;
                        for (int i = 0; i < 4; i++)
                            if (!dram_cas_n[i]) w[i*8 +: 8] = dram_dq_out[i*8 +: 8];
                        dmem[key] = w;
                    end
                end else begin
                    chk(dram_cas_n == 4'h0 && dram_we_n, "R7 read strobes",
                        {dram_cas_n, dram_we_n}, 64'h1);
                    dram_dq_in = dmem.exists(key) ? dmem[key] : 32'h0;
                end
                cas_lo = 0;
            end
            if (p_cas != 4'hF && dram_cas_n == 4'hF) begin
                chk(cas_lo >= TCAS_CYC, "R8 column strobe width", 64'(cas_lo), 64'(TCAS_CYC));
                dram_dq_in = 32'h0BAD_F00D;
            end
            if (p_ras != 2'b11 && dram_ras_n == 2'b11)
                chk(ras_lo >= TRAS_CYC, "R8 active width", 64'(ras_lo), 64'(TRAS_CYC));
            if (!ref_err) total++;
            else chk(1'b0, "R11 no error on main instance", 64'(ref_err), 64'h0);
            // history
            if (dram_ras_n == 2'b11) begin ras_hi++; ras_lo = 0; end
            else begin ras_lo++; ras_hi = 0; end
            if (dram_cas_n != 4'hF) cas_lo++;
            since_fall++;
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_addr = dram_addr;
        end
    end

    // one host access; waits until the row strobe rises again
    task automatic access(input logic wr, input logic [22:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] exp_r;
        e_wr = wr; e_a = a; e_d = d; e_be = be;
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; host_be = be;
        do @(negedge clk); while (!host_ack);
        chk(ready && init_refs == INIT_REFS, "R2 ack only after init refreshes",
            {ready, 32'(init_refs)}, {1'b1, 32'(INIT_REFS)});
        host_req = 1'b0;
        @(negedge clk);
        while (dram_ras_n != 2'b11) @(negedge clk);
        if (wr) begin
            logic [31:0] w;
            w = hmem.exists(int'(a)) ? hmem[int'(a)] : 32'h0;
            for (int i = 0; i < 4; i++)
                if (be[i]) w[i*8 +: 8] = d[i*8 +: 8];
            hmem[int'(a)] = w;
        end else begin
            exp_r = hmem.exists(int'(a)) ? hmem[int'(a)] : 32'h0;
            chk(host_rvalid && host_rdata == exp_r, "R7 read data", {host_rvalid, host_rdata}, {1'b1, exp_r});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk(dram_ras_n == 2'b11 && dram_cas_n == 4'hF && dram_we_n && !host_ack && !ready && !ref_err,
            "R1 reset state", {dram_ras_n, dram_cas_n, dram_we_n, host_ack, ready, ref_err}, {2'b11, 4'hF, 4'b1000});
        // request raised during the pause
        access(1'b1, 23'h000000, 32'h1122_3344, 4'hF);
        access(1'b0, 23'h000000, 32'h0, 4'h0);
        // rank 1 at the same row and column must not alias rank 0
        access(1'b1, 23'h400000, 32'hA5A5_5A5A, 4'hF);
        access(1'b0, 23'h000000, 32'h0, 4'h0);
        access(1'b0, 23'h400000, 32'h0, 4'h0);
        // extreme row and column
        access(1'b1, 23'h3FFFFF, 32'hDEAD_BEEF, 4'hF);
        access(1'b1, 23'h7FFFFF, 32'hCAFE_F00D, 4'hF);
        access(1'b0, 23'h3FFFFF, 32'h0, 4'h0);
        access(1'b0, 23'h7FFFFF, 32'h0, 4'h0);
        // partial byte enables leave the other lanes alone
        access(1'b1, 23'h3FFFFF, 32'h0000_0077, 4'b0001);
        access(1'b1, 23'h3FFFFF, 32'h6600_0000, 4'b1000);
        access(1'b1, 23'h3FFFFF, 32'hFFFF_FFFF, 4'b0000);
        access(1'b0, 23'h3FFFFF, 32'h0, 4'h0);
        // back-to-back mixed traffic spanning several refresh intervals
        for (int n = 0; n < 400; n++) begin
            logic [22:0] a;
            a = {1'($urandom_range(0, 1)), 12'($urandom_range(0, 3) * 12'h555), 10'($urandom_range(0, 7) * 10'h49)};
            access(1'($urandom_range(0, 1)), a, $urandom, 4'($urandom_range(0, 15)));
        end
        repeat (3000) @(negedge clk);
        chk(late_refs >= 4, "R10 periodic refreshes seen", 64'(late_refs), 64'd4);
        chk(b_err == 1'b1, "R11 error on short interval", 64'(b_err), 64'h1);
        chk(ref_err == 1'b0, "R11 main instance clean", 64'(ref_err), 64'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule